// File: doc/BRIEF.md
# Extended-to-Single/Double Rounding Packer

This block converts one operand held in a wide internal floating-point form into an IEEE single- or double-precision bit pattern. The internal form is a sign, an unbiased signed exponent, a 64-bit significand whose top bit is the explicit integer bit, and a two-bit class tag. A caller supplies the target format, a two-bit rounding mode and four exception mask bits with each operand. The block rounds the significand to the target width and renormalizes on a carry out. It detects overflow, builds denormal results for tiny exponents, and encodes zeros, infinities, NaNs and the empty-register case.

The result is registered, so it appears one cycle after the request. `out_done` marks every completed request and `out_we` says whether the packed word should be written to memory. The six exception flags pulse with `out_done` and are meant to be OR-ed into a sticky status word outside the block. When an exception that the result depends on is unmasked, the write is withheld so that a trap handler sees memory untouched.

Top module: `xf_narrow_packer`

## Requirements
- R1: While `rst` is high, `out_done`, `out_we` and all six flags are 0 on the clock edge after it is sampled, whatever the inputs.
- R2: `out_done` is 1 exactly one cycle after a cycle with `in_valid` high and 0 otherwise; `out_we` and every flag are 0 whenever `out_done` is 0.
- R3: Rounding mode 0 (nearest-even) increments the kept significand when the discarded part exceeds half an ulp, or equals half and the lowest kept bit is 1.
- R4: Mode 1 (toward minus infinity) increments the magnitude only for a negative value with nonzero discarded bits; mode 2 (toward plus infinity) only for a positive one; mode 3 (truncate) never increments.
- R5: An increment that carries out of the kept significand yields fraction 0 and an exponent one higher.
- R6: A rounded exponent above the format maximum (127 single, 1023 double) sets the overflow, precision and rounded-up flags; the block writes a signed infinity only if `in_mask` bit 1 (overflow) and bit 3 (precision) are both 1.
- R7: An exponent below the format minimum (-126 / -1022) gives a denormal that is rounded under the current mode (rounding up may reach the smallest normal); underflow and precision are flagged only if bits were lost, and then the write happens only if `in_mask` bit 2 (underflow) and bit 3 are both 1.
- R8: Tag 2 with a nonzero fraction is a NaN: its top fraction bits are kept and the exponent field is all ones; if significand bit 62 is 0 the invalid flag is set, and with `in_mask` bit 0 (invalid) at 1 bit 62's position is set to 1 in the result; with bit 0 at 0 nothing is written.
- R9: Tag 2 with a zero fraction yields a signed infinity and tag 1 yields a signed zero, both written with no flags and regardless of the significand.
- R10: Tag 3 (empty) sets the stack-underflow flag; with `in_mask` bit 0 at 1 the word is 0xFFC00000 (single) or 0xFFF8000000000000 (double), with it at 0 nothing is written.
- R11: An inexact result sets the precision flag, and the rounded-up flag exactly when an increment was applied; an inexact normal-range result is written whatever the precision mask.
- R12: A single-precision result occupies `out_word[31:0]` with `out_word[63:32]` zero; a double result uses all 64 bits, sign in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; the operand fields below are sampled with it |
| in_dbl | input | 1 | Target format: 0 single, 1 double |
| in_rnd | input | 2 | Rounding mode: 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 truncate |
| in_mask | input | 4 | Exception masks, 1 = masked: bit 0 invalid, bit 1 overflow, bit 2 underflow, bit 3 precision |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | 18 | Unbiased exponent, two's complement |
| in_sig | input | 64 | Significand, bit 63 is the integer bit |
| in_tag | input | 2 | Class: 0 number, 1 zero, 2 infinity or NaN, 3 empty |
| out_done | output | 1 | Result of the previous cycle's request is present |
| out_we | output | 1 | The packed word should be written |
| out_word | output | 64 | Packed result |
| flag_prec | output | 1 | Precision lost |
| flag_up | output | 1 | The magnitude was rounded up |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inv | output | 1 | Invalid operation (signalling NaN) |
| flag_stk | output | 1 | Stack underflow (empty source) |

## Verification
Rounding and exponent range checks can act on the same operand: a significand of all ones with the maximum exponent rounds up, carries, and only then overflows, and an all-ones significand just below the minimum exponent rounds from a denormal into the smallest normal while still reporting underflow. The stimulus table contains both cases under nearest-even, and the expected word and flag set are worked out from the requirements, so a design that checks the range before applying the carry produces a finite word or a missing flag and is reported. The same table pairs each masked exception with its unmasked twin to judge write suppression against the flags.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

    localparam int DEF_SIG_W = 64;
    localparam int DEF_EXP_W = 18;
    localparam int OUT_W     = 64;

    localparam int MSK_INV  = 0;
    localparam int MSK_OVF  = 1;
    localparam int MSK_UNF  = 2;
    localparam int MSK_PREC = 3;

    typedef enum logic [1:0] {
        TAG_NUM     = 2'd0,
        TAG_ZERO    = 2'd1,
        TAG_SPECIAL = 2'd2,
        TAG_EMPTY   = 2'd3
    } src_tag_e;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_DOWN    = 2'd1,
        RND_UP      = 2'd2,
        RND_TRUNC   = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic stk;
        logic inv;
        logic unf;
        logic ovf;
        logic up;
        logic prec;
    } pk_flags_t;

    localparam logic [OUT_W-1:0] EMPTY_DBL = 64'hFFF8_0000_0000_0000;
    localparam logic [OUT_W-1:0] EMPTY_SGL = 64'h0000_0000_FFC0_0000;

    function automatic int frac_bits(input logic dbl);
        return dbl ? 52 : 23;
    endfunction

    function automatic int exp_bias(input logic dbl);
        return dbl ? 1023 : 127;
    endfunction

    function automatic int word_bits(input logic dbl);
        return dbl ? 64 : 32;
    endfunction

endpackage

// File: rtl/pk_align.sv
module pk_align
    import fpk_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int EXP_W = DEF_EXP_W,
    parameter int SH_W  = $clog2(2 * SIG_W)
) (
    input  logic                    dbl,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [SIG_W-1:0]        sig,
    output logic [SIG_W-1:0]        kept,
    output logic                    guard,
    output logic                    sticky,
    output logic                    tiny
);
    localparam int SH_MAX = (1 << SH_W) - 1;

    always_comb begin
        int gap;
        int sh;
        logic [SH_W-1:0]  sh_c;
        logic [SH_W-1:0]  pos;
        logic [SIG_W-1:0] hot;
        logic [SIG_W-1:0] below;

        // distance below the smallest normal exponent of the target format
        gap  = (1 - exp_bias(dbl)) - int'(exp_in);
        tiny = (gap > 0);
        sh   = (SIG_W - 1) - frac_bits(dbl) + (tiny ? gap : 0);
        if (sh > SH_MAX) sh = SH_MAX;
        sh_c = SH_W'(sh);
        pos  = sh_c - SH_W'(1);

        hot    = (int'(pos) < SIG_W) ? (SIG_W'(1) << pos) : '0;
        below  = (int'(pos) < SIG_W) ? (hot - SIG_W'(1)) : '1;
        kept   = (int'(sh_c) < SIG_W) ? (sig >> sh_c) : '0;
        guard  = |(sig & hot);
        sticky = |(sig & below);
    end

endmodule

// File: rtl/pk_round.sv
module pk_round
    import fpk_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      neg,
    input  logic      lsb,
    input  logic      guard,
    input  logic      sticky,
    output logic      inc,
    output logic      inexact
);
    always_comb begin
        inexact = guard | sticky;
        unique case (mode)
            RND_NEAREST: inc = guard & (sticky | lsb);
            RND_DOWN:    inc = neg & inexact;
            RND_UP:      inc = ~neg & inexact;
            RND_TRUNC:   inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/pk_encode.sv
module pk_encode
    import fpk_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int EXP_W = DEF_EXP_W
) (
    input  logic                    dbl,
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [SIG_W-1:0]        sig,
    input  src_tag_e                tag,
    input  logic [3:0]              mask,
    input  logic [SIG_W-1:0]        kept,
    input  logic                    tiny,
    input  logic                    inc,
    input  logic                    inexact,
    output logic [OUT_W-1:0]        word,
    output logic                    we,
    output pk_flags_t               flags
);
    always_comb begin
        int f;
        int w;
        int bias;
        int eadj;
        logic [SIG_W-1:0] sum;
        logic             carry;
        logic [OUT_W-1:0] fmask;
        logic [OUT_W-1:0] sbit;
        logic [OUT_W-1:0] eall;
        logic [OUT_W-1:0] frac;

        f     = frac_bits(dbl);
        w     = word_bits(dbl);
        bias  = exp_bias(dbl);
        sum   = kept + SIG_W'(inc);
        carry = !tiny && ((sum >> (f + 1)) != '0);
        eadj  = int'(exp_in) + (carry ? 1 : 0);
        fmask = (OUT_W'(1) << f) - OUT_W'(1);
        sbit  = sign ? (OUT_W'(1) << (w - 1)) : '0;
        eall  = ((OUT_W'(1) << (w - 1 - f)) - OUT_W'(1)) << f;
        frac  = (OUT_W'(sig) >> (SIG_W - 1 - f)) & fmask;

        word  = '0;
        we    = 1'b1;
        flags = '0;

        unique case (tag)
            TAG_NUM: begin
                if (tiny) begin
                    // denormal: the carry lands in the exponent field by itself
                    word       = sbit | OUT_W'(sum);
                    flags.prec = inexact;
                    flags.up   = inc;
                    flags.unf  = inexact;
                    we         = !(inexact && !(mask[MSK_UNF] && mask[MSK_PREC]));
                end else if (eadj > bias) begin
                    word       = sbit | eall;
                    flags.ovf  = 1'b1;
                    flags.prec = 1'b1;
                    flags.up   = 1'b1;
                    we         = mask[MSK_OVF] && mask[MSK_PREC];
                end else begin
                    word       = sbit | (OUT_W'(eadj + bias) << f) | (OUT_W'(sum) & fmask);
                    flags.prec = inexact;
                    flags.up   = inc;
                end
            end
            TAG_ZERO: word = sbit;
            TAG_SPECIAL: begin
                if (sig[SIG_W-2:0] == '0) begin
                    word = sbit | eall;
                end else begin
                    if (!sig[SIG_W-2]) begin
                        flags.inv = 1'b1;
                        frac      = frac | (OUT_W'(1) << (f - 1));
                        we        = mask[MSK_INV];
                    end
                    word = sbit | eall | frac;
                end
            end
            TAG_EMPTY: begin
                flags.stk = 1'b1;
                word      = dbl ? EMPTY_DBL : EMPTY_SGL;
                we        = mask[MSK_INV];
            end
        endcase
    end

endmodule

// File: rtl/xf_narrow_packer.sv
module xf_narrow_packer
    import fpk_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int EXP_W = DEF_EXP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_dbl,
    input  logic [1:0]              in_rnd,
    input  logic [3:0]              in_mask,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0]        in_sig,
    input  logic [1:0]              in_tag,
    output logic                    out_done,
    output logic                    out_we,
    output logic [OUT_W-1:0]        out_word,
    output logic                    flag_prec,
    output logic                    flag_up,
    output logic                    flag_ovf,
    output logic                    flag_unf,
    output logic                    flag_inv,
    output logic                    flag_stk
);
    logic [SIG_W-1:0] kept;
    logic             guard, sticky, tiny;
    logic             inc, inexact;
    logic [OUT_W-1:0] word_c;
    logic             we_c;
    pk_flags_t        flags_c, flags_q;

    pk_align #(.SIG_W(SIG_W), .EXP_W(EXP_W)) align_i (
        .dbl    (in_dbl),
        .exp_in (in_exp),
        .sig    (in_sig),
        .kept   (kept),
        .guard  (guard),
        .sticky (sticky),
        .tiny   (tiny)
    );

    pk_round round_i (
        .mode    (rnd_mode_e'(in_rnd)),
        .neg     (in_sign),
        .lsb     (kept[0]),
        .guard   (guard),
        .sticky  (sticky),
        .inc     (inc),
        .inexact (inexact)
    );

    pk_encode #(.SIG_W(SIG_W), .EXP_W(EXP_W)) encode_i (
        .dbl     (in_dbl),
        .sign    (in_sign),
        .exp_in  (in_exp),
        .sig     (in_sig),
        .tag     (src_tag_e'(in_tag)),
        .mask    (in_mask),
        .kept    (kept),
        .tiny    (tiny),
        .inc     (inc),
        .inexact (inexact),
        .word    (word_c),
        .we      (we_c),
        .flags   (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done <= 1'b0;
            out_we   <= 1'b0;
            out_word <= '0;
            flags_q  <= '0;
        end else begin
            out_done <= in_valid;
            out_we   <= in_valid & we_c;
            flags_q  <= in_valid ? flags_c : '0;
            if (in_valid) out_word <= word_c;
        end
    end

    assign flag_prec = flags_q.prec;
    assign flag_up   = flags_q.up;
    assign flag_ovf  = flags_q.ovf;
    assign flag_unf  = flags_q.unf;
    assign flag_inv  = flags_q.inv;
    assign flag_stk  = flags_q.stk;

endmodule

// File: rtl/pk_narrow_chk.sv
module pk_narrow_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_dbl,
    input logic [3:0]  in_mask,
    input logic        out_done,
    input logic        out_we,
    input logic [63:0] out_word,
    input logic        flag_prec,
    input logic        flag_up,
    input logic        flag_ovf,
    input logic        flag_unf,
    input logic        flag_inv,
    input logic        flag_stk
);
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> !out_we && !(flag_prec | flag_up | flag_ovf | flag_unf | flag_inv | flag_stk));

    assert_up_implies_prec_R11: assert property (@(posedge clk) disable iff (rst)
        flag_up |-> flag_prec);

    assert_unf_implies_prec_R7: assert property (@(posedge clk) disable iff (rst)
        flag_unf |-> flag_prec);

    assert_ovf_unmasked_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_ovf && !($past(in_mask[1]) && $past(in_mask[3]))) |-> !out_we);

    assert_unf_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_unf && !($past(in_mask[2]) && $past(in_mask[3]))) |-> !out_we);

    assert_inv_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        ((flag_inv || flag_stk) && !$past(in_mask[0])) |-> !out_we);

    assert_empty_pattern_R10: assert property (@(posedge clk) disable iff (rst)
        (out_we && flag_stk) |->
            out_word == ($past(in_dbl) ? 64'hFFF8_0000_0000_0000 : 64'h0000_0000_FFC0_0000));

    assert_single_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (out_done && !$past(in_dbl)) |-> out_word[63:32] == 32'h0);

endmodule

bind xf_narrow_packer pk_narrow_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dbl    (in_dbl),
    .in_mask   (in_mask),
    .out_done  (out_done),
    .out_we    (out_we),
    .out_word  (out_word),
    .flag_prec (flag_prec),
    .flag_up   (flag_up),
    .flag_ovf  (flag_ovf),
    .flag_unf  (flag_unf),
    .flag_inv  (flag_inv),
    .flag_stk  (flag_stk)
);

// File: tb/xf_narrow_packer_tb_top.sv
`timescale 1ns/1ps
module xf_narrow_packer_tb_top;

    typedef struct packed {
        logic [3:0]  req;
        logic        dbl;
        logic [1:0]  rnd;
        logic [3:0]  msk;
        logic        sgn;
        logic [17:0] ex;
        logic [63:0] sg;
        logic [1:0]  tg;
        logic        we;
        logic [63:0] wd;
        logic [5:0]  fl;   // {stk, inv, unf, ovf, up, prec}
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        // R3 nearest-even, exact values
        '{4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0000_0000_3F80_0000, 6'b000000},
        '{4'd3, 1'b1, 2'd0, 4'hF, 1'b1, 18'sd0, 64'hC000_0000_0000_0000, 2'd0, 1'b1, 64'hBFF8_0000_0000_0000, 6'b000000},
        // R3 exact half, even lsb stays; odd lsb goes up; above half goes up
        '{4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0080_0000_0000, 2'd0, 1'b1, 64'h0000_0000_3F80_0000, 6'b000001},
        '{4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0180_0000_0000, 2'd0, 1'b1, 64'h0000_0000_3F80_0002, 6'b000011},
        '{4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0080_0000_0001, 2'd0, 1'b1, 64'h0000_0000_3F80_0001, 6'b000011},
        // R4 directed modes
        '{4'd4, 1'b0, 2'd1, 4'hF, 1'b1, 18'sd0, 64'h8000_0000_0000_0001, 2'd0, 1'b1, 64'h0000_0000_BF80_0001, 6'b000011},
        '{4'd4, 1'b0, 2'd1, 4'hF, 1'b0, 18'sd0, 64'h8000_0000_0000_0001, 2'd0, 1'b1, 64'h0000_0000_3F80_0000, 6'b000001},
        '{4'd4, 1'b0, 2'd2, 4'hF, 1'b0, 18'sd0, 64'h8000_0000_0000_0001, 2'd0, 1'b1, 64'h0000_0000_3F80_0001, 6'b000011},
        '{4'd4, 1'b0, 2'd2, 4'hF, 1'b1, 18'sd0, 64'h8000_0000_0000_0001, 2'd0, 1'b1, 64'h0000_0000_BF80_0000, 6'b000001},
        // R12 truncate of all ones: full single fraction, upper half zero
        '{4'd12, 1'b0, 2'd3, 4'hF, 1'b0, 18'sd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 64'h0000_0000_3FFF_FFFF, 6'b000001},
        // R5 carry renormalizes
        '{4'd5, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 64'h0000_0000_4000_0000, 6'b000011},
        // R6 overflow
        '{4'd6, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd128, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0000_0000_7F80_0000, 6'b000111},
        '{4'd6, 1'b0, 2'd0, 4'hF, 1'b1, 18'sd127, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 64'h0000_0000_FF80_0000, 6'b000111},
        '{4'd6, 1'b0, 2'd0, 4'hD, 1'b0, 18'sd128, 64'h8000_0000_0000_0000, 2'd0, 1'b0, 64'h0, 6'b000111},
        '{4'd6, 1'b0, 2'd0, 4'h7, 1'b0, 18'sd128, 64'h8000_0000_0000_0000, 2'd0, 1'b0, 64'h0, 6'b000111},
        // R3 double half with odd lsb
        '{4'd3, 1'b1, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0000_0000_0C00, 2'd0, 1'b1, 64'h3FF0_0000_0000_0002, 6'b000011},
        // R6 double overflow
        '{4'd6, 1'b1, 2'd0, 4'hF, 1'b0, 18'sd1024, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h7FF0_0000_0000_0000, 6'b000111},
        // R7 denormals
        '{4'd7, 1'b0, 2'd0, 4'hF, 1'b0, -18'sd127, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0000_0000_0040_0000, 6'b000000},
        '{4'd7, 1'b0, 2'd0, 4'hF, 1'b0, -18'sd130, 64'h8000_0000_0000_0001, 2'd0, 1'b1, 64'h0000_0000_0008_0000, 6'b001001},
        '{4'd7, 1'b0, 2'd0, 4'hB, 1'b0, -18'sd130, 64'h8000_0000_0000_0001, 2'd0, 1'b0, 64'h0, 6'b001001},
        '{4'd7, 1'b0, 2'd0, 4'h7, 1'b0, -18'sd130, 64'h8000_0000_0000_0001, 2'd0, 1'b0, 64'h0, 6'b001001},
        '{4'd7, 1'b0, 2'd0, 4'hF, 1'b0, -18'sd127, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 64'h0000_0000_0080_0000, 6'b001011},
        '{4'd7, 1'b0, 2'd0, 4'hF, 1'b0, -18'sd300, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0000_0000_0000_0000, 6'b001001},
        '{4'd7, 1'b0, 2'd2, 4'hF, 1'b0, -18'sd300, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0000_0000_0000_0001, 6'b001011},
        '{4'd7, 1'b1, 2'd0, 4'hF, 1'b0, -18'sd1023, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 64'h0008_0000_0000_0000, 6'b000000},
        // R11 inexact normal result still written with precision unmasked
        '{4'd11, 1'b0, 2'd0, 4'h7, 1'b0, 18'sd0, 64'h8000_0080_0000_0001, 2'd0, 1'b1, 64'h0000_0000_3F80_0001, 6'b000011},
        // R9 infinities
        '{4'd9, 1'b0, 2'd0, 4'hF, 1'b1, 18'sd0, 64'h8000_0000_0000_0000, 2'd2, 1'b1, 64'h0000_0000_FF80_0000, 6'b000000},
        '{4'd9, 1'b1, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h8000_0000_0000_0000, 2'd2, 1'b1, 64'h7FF0_0000_0000_0000, 6'b000000},
        // R8 NaNs
        '{4'd8, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'hC000_0000_0000_0000, 2'd2, 1'b1, 64'h0000_0000_7FC0_0000, 6'b000000},
        '{4'd8, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'hA000_0000_0000_0000, 2'd2, 1'b1, 64'h0000_0000_7FE0_0000, 6'b010000},
        '{4'd8, 1'b0, 2'd0, 4'hE, 1'b0, 18'sd0, 64'hA000_0000_0000_0000, 2'd2, 1'b0, 64'h0, 6'b010000},
        '{4'd8, 1'b1, 2'd0, 4'hF, 1'b1, 18'sd0, 64'h8000_0000_0000_0800, 2'd2, 1'b1, 64'hFFF8_0000_0000_0001, 6'b010000},
        // R9 zeros ignore the significand
        '{4'd9, 1'b0, 2'd0, 4'hF, 1'b1, 18'sd5, 64'h1234_5678_9ABC_DEF0, 2'd1, 1'b1, 64'h0000_0000_8000_0000, 6'b000000},
        '{4'd9, 1'b1, 2'd1, 4'hF, 1'b0, 18'sd5, 64'h1234_5678_9ABC_DEF0, 2'd1, 1'b1, 64'h0000_0000_0000_0000, 6'b000000},
        // R10 empty source
        '{4'd10, 1'b0, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h0, 2'd3, 1'b1, 64'h0000_0000_FFC0_0000, 6'b100000},
        '{4'd10, 1'b1, 2'd0, 4'hF, 1'b0, 18'sd0, 64'h0, 2'd3, 1'b1, 64'hFFF8_0000_0000_0000, 6'b100000},
        '{4'd10, 1'b1, 2'd0, 4'hE, 1'b0, 18'sd0, 64'h0, 2'd3, 1'b0, 64'h0, 6'b100000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [1:0]  in_rnd = 2'd0;
    logic [3:0]  in_mask = 4'hF;
    logic        in_sign = 1'b0;
    logic [17:0] in_exp = 18'd0;
    logic [63:0] in_sig = 64'd0;
    logic [1:0]  in_tag = 2'd0;
    logic        out_done, out_we;
    logic [63:0] out_word;
    logic        flag_prec, flag_up, flag_ovf, flag_unf, flag_inv, flag_stk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xf_narrow_packer dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_dbl    (in_dbl),
        .in_rnd    (in_rnd),
        .in_mask   (in_mask),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_sig    (in_sig),
        .in_tag    (in_tag),
        .out_done  (out_done),
        .out_we    (out_we),
        .out_word  (out_word),
        .flag_prec (flag_prec),
        .flag_up   (flag_up),
        .flag_ovf  (flag_ovf),
        .flag_unf  (flag_unf),
        .flag_inv  (flag_inv),
        .flag_stk  (flag_stk)
    );

    function automatic logic [5:0] flags_now();
        return {flag_stk, flag_inv, flag_unf, flag_ovf, flag_up, flag_prec};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_dbl   = v.dbl;
        in_rnd   = v.rnd;
        in_mask  = v.msk;
        in_sign  = v.sgn;
        in_exp   = v.ex;
        in_sig   = v.sg;
        in_tag   = v.tg;
        in_valid = 1'b1;
    endtask

    task automatic judge(input vec_t v, input int idx);
        string r;
        r = $sformatf("R%0d vec%0d", v.req, idx);
        check(r, "done", 64'(out_done), 64'd1);
        check(r, "write enable", 64'(out_we), 64'(v.we));
        check(r, "flags", 64'(flags_now()), 64'(v.fl));
        if (v.we) check(r, "word", out_word, v.wd);
    endtask

    initial begin
        // R1: reset holds outputs low even with a request present
        drive(VECS[11]);
        repeat (3) @(negedge clk);
        check("R1", "done in reset", 64'(out_done), 64'd0);
        check("R1", "we in reset", 64'(out_we), 64'd0);
        check("R1", "flags in reset", 64'(flags_now()), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // table walk: inputs change at a falling edge, result read one edge later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            judge(VECS[i], i);
        end

        // R2: an idle cycle after a result clears done, write and flags
        drive(VECS[11]);
        @(negedge clk);
        in_valid = 1'b0;
        judge(VECS[11], 11);
        @(negedge clk);
        check("R2", "done after idle", 64'(out_done), 64'd0);
        check("R2", "we after idle", 64'(out_we), 64'd0);
        check("R2", "flags after idle", 64'(flags_now()), 64'd0);

        // R2: back-to-back requests each appear exactly one cycle later
        drive(VECS[3]);
        @(negedge clk);
        judge(VECS[3], 3);
        drive(VECS[29]);
        @(negedge clk);
        in_valid = 1'b0;
        judge(VECS[29], 29);
        @(negedge clk);
        check("R2", "done after burst", 64'(out_done), 64'd0);

        // R1: reset in the middle of traffic clears the outputs
        drive(VECS[34]);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "done on mid reset", 64'(out_done), 64'd0);
        check("R1", "flags on mid reset", 64'(flags_now()), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual=running expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule